// File: doc/BRIEF.md
# Packing Block-Transfer Engine

This engine moves a run of 16-bit words between a local word memory and a peripheral bus that has its own address space. One command names the direction, a packing mode, a memory base address, a bus base address and a word count. Going out, every memory word is cut into one, two or four bus items. Coming in, bus items are gathered back into whole words before each memory write. Both address spaces are walked from their highest address down to their lowest.

Both the memory side and the bus side are simple synchronous request/ready ports. A transfer completes on a clock edge where request and ready are both high. Before the first item of a transfer, the engine raises a single-cycle bus control strobe that announces read or write. A one-cycle completion pulse ends every command, including an empty one.

Top module: `pack_xfer_engine`

## Requirements
- R1: A start pulse is taken only while the engine is idle. A start pulse that arrives during a transfer changes neither the transfer in progress nor its results, and it produces no second completion pulse.
- R2: When count is 0, `done` goes high in the cycle after the start is taken. No control strobe, memory transfer or bus transfer follows.
- R3: For a nonzero count, `bus_ctl_stb` is high for exactly one cycle before the first item, and no request is active in that cycle. `bus_ctl` is 1 when `cmd_dir`=1 (bus to memory) and 2 when `cmd_dir`=0 (memory to bus).
- R4: Memory words are accessed one per step. The first access is at base+count−1, and each later access is one address lower, ending at base.
- R5: The first bus item is at bus_base + count·k − 1, where k is 1 for `cmd_size`=0, 2 for `cmd_size`=1 or 2, and 4 for `cmd_size`=3. Each later item is one address lower.
- R6: With size 0 (word), each word is a single 16-bit bus item.
- R7: With size 1 (bytes) going out, the high byte goes first and the low byte second. Each byte is placed on `bus_wdata[7:0]`, and bits 15:8 are zero.
- R8: With size 2 (swapped bytes) going out, the low byte goes first and the high byte second. Upper bits are zero.
- R9: With size 3 (nibbles) going out, four items are sent in the order bits 3:0, 7:4, 11:8, 15:12. Each item is placed on `bus_wdata[3:0]`, and the remaining bits are zero.
- R10: Coming in, words are assembled as the exact inverse of R6–R9, so the same bus image gives back the same word. Bits of `bus_rdata` above the item width are ignored.
- R11: A request holds its address, direction and write data steady until ready is seen.
- R12: `done` is a one-cycle pulse that follows the final memory or bus transfer. Memory and bus requests are never active together, and neither is active while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start pulse |
| cmd_dir | input | 1 | 0 memory to bus, 1 bus to memory |
| cmd_size | input | 2 | Packing mode: 0 word, 1 bytes, 2 swapped bytes, 3 nibbles |
| cmd_mem_base | input | MEM_AW | Lowest memory word address |
| cmd_bus_base | input | BUS_AW | Lowest bus item address |
| cmd_count | input | CNT_W | Number of words |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | MEM_AW | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid when ready is high |
| mem_rdy | input | 1 | Memory ready |
| bus_ctl_stb | output | 1 | Bus control strobe |
| bus_ctl | output | 2 | Bus control code: 1 read, 2 write |
| bus_req | output | 1 | Bus item request |
| bus_we | output | 1 | Bus write enable |
| bus_addr | output | BUS_AW | Bus item address |
| bus_wdata | output | 16 | Bus item write data |
| bus_rdata | input | 16 | Bus item read data, valid when ready is high |
| bus_rdy | input | 1 | Bus ready |
| done | output | 1 | Completion pulse |

## Verification
Some properties are checked on every cycle. Each accepted transfer lowers its port address by exactly one. A stalled request keeps its address and data steady. The two ports are never requested together, the control strobe stands alone for a single cycle with a legal code, and completion never overlaps a request. Other behaviours can only be seen through the bench's scenarios. These are the byte and nibble ordering in each mode, the reassembly of bytes and nibbles into words on input, the start addresses computed from count and mode, the empty command, and a start pulse ignored during a transfer. The bench checks them by comparing full memory and bus images against a reference model, under random ready stalls.

// File: rtl/pxe_pkg.sv
package pxe_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    SZ_WORD  = 2'd0,
    SZ_BYTE  = 2'd1,
    SZ_BSWAP = 2'd2,
    SZ_NIB   = 2'd3
  } size_e;

  localparam logic [1:0] CTL_RD = 2'd1;
  localparam logic [1:0] CTL_WR = 2'd2;
endpackage

// File: rtl/pxe_addr_init.sv
module pxe_addr_init
  import pxe_pkg::*;
#(
  parameter int MEM_AW = 10,
  parameter int BUS_AW = 12,
  parameter int CNT_W  = 8
) (
  input  size_e             size,
  input  logic [MEM_AW-1:0] mem_base,
  input  logic [BUS_AW-1:0] bus_base,
  input  logic [CNT_W-1:0]  count,
  output logic [MEM_AW-1:0] mem_top,
  output logic [BUS_AW-1:0] bus_top
);
  logic [BUS_AW-1:0] cnt_b;
  logic [BUS_AW-1:0] items;

  assign cnt_b = BUS_AW'(count);

  always_comb begin
    unique case (size)
      SZ_WORD:           items = cnt_b;
      SZ_BYTE, SZ_BSWAP: items = cnt_b << 1;
      default:           items = cnt_b << 2;
    endcase
  end

  assign mem_top = mem_base + MEM_AW'(count) - MEM_AW'(1);
  assign bus_top = bus_base + items - BUS_AW'(1);
endmodule

// File: rtl/pxe_repack.sv
module pxe_repack
  import pxe_pkg::*;
(
  input  size_e              size,
  input  logic [WORD_W-1:0]  mem_word,
  input  logic [WORD_W-1:0]  cur,
  input  logic [WORD_W-1:0]  rd_item,
  output logic [WORD_W-1:0]  load_val,
  output logic [WORD_W-1:0]  load_item,
  output logic [WORD_W-1:0]  rot_val,
  output logic [WORD_W-1:0]  rot_item,
  output logic [WORD_W-1:0]  asm_val,
  output logic [1:0]         last_idx
);
  function automatic logic [WORD_W-1:0] trim(input size_e s, input logic [WORD_W-1:0] v);
    unique case (s)
      SZ_WORD:           trim = v;
      SZ_BYTE, SZ_BSWAP: trim = {8'h00, v[7:0]};
      default:           trim = {12'h000, v[3:0]};
    endcase
  endfunction

  always_comb begin
    unique case (size)
      SZ_WORD: begin
        load_val = mem_word;
        rot_val  = cur;
        asm_val  = rd_item;
        last_idx = 2'd0;
      end
      SZ_BYTE: begin
        load_val = {mem_word[7:0], mem_word[15:8]};
        rot_val  = {cur[7:0], cur[15:8]};
        asm_val  = {cur[7:0], rd_item[7:0]};
        last_idx = 2'd1;
      end
      SZ_BSWAP: begin
        load_val = mem_word;
        rot_val  = {cur[7:0], cur[15:8]};
        asm_val  = {rd_item[7:0], cur[15:8]};
        last_idx = 2'd1;
      end
      default: begin
        load_val = mem_word;
        rot_val  = {cur[3:0], cur[15:4]};
        asm_val  = {rd_item[3:0], cur[15:4]};
        last_idx = 2'd3;
      end
    endcase
  end

  assign load_item = trim(size, load_val);
  assign rot_item  = trim(size, rot_val);
endmodule

// File: rtl/pack_xfer_engine.sv
module pack_xfer_engine
  import pxe_pkg::*;
#(
  parameter int MEM_AW = 10,
  parameter int BUS_AW = 12,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_start,
  input  logic              cmd_dir,
  input  logic [1:0]        cmd_size,
  input  logic [MEM_AW-1:0] cmd_mem_base,
  input  logic [BUS_AW-1:0] cmd_bus_base,
  input  logic [CNT_W-1:0]  cmd_count,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  input  logic              mem_rdy,
  output logic              bus_ctl_stb,
  output logic [1:0]        bus_ctl,
  output logic              bus_req,
  output logic              bus_we,
  output logic [BUS_AW-1:0] bus_addr,
  output logic [15:0]       bus_wdata,
  input  logic [15:0]       bus_rdata,
  input  logic              bus_rdy,
  output logic              done
);
  localparam int DW = WORD_W;

  typedef enum logic [2:0] {S_IDLE, S_CTL, S_MRD, S_BOUT, S_BIN, S_MWR} state_e;

  state_e            state;
  logic              dir_q;
  size_e             size_q;
  logic [CNT_W-1:0]  words_left;
  logic [1:0]        item_idx;
  logic [DW-1:0]     data_q;

  logic [MEM_AW-1:0] mem_top;
  logic [BUS_AW-1:0] bus_top;
  logic [DW-1:0]     load_val, load_item, rot_val, rot_item, asm_val;
  logic [1:0]        last_idx;
  logic              last_word;

  pxe_addr_init #(.MEM_AW(MEM_AW), .BUS_AW(BUS_AW), .CNT_W(CNT_W)) u_addr (
    .size     (size_e'(cmd_size)),
    .mem_base (cmd_mem_base),
    .bus_base (cmd_bus_base),
    .count    (cmd_count),
    .mem_top  (mem_top),
    .bus_top  (bus_top)
  );

  pxe_repack u_pack (
    .size      (size_q),
    .mem_word  (mem_rdata),
    .cur       (data_q),
    .rd_item   (bus_rdata),
    .load_val  (load_val),
    .load_item (load_item),
    .rot_val   (rot_val),
    .rot_item  (rot_item),
    .asm_val   (asm_val),
    .last_idx  (last_idx)
  );

  assign last_word = (words_left == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      dir_q       <= 1'b0;
      size_q      <= SZ_WORD;
      words_left  <= '0;
      item_idx    <= '0;
      data_q      <= '0;
      mem_req     <= 1'b0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      bus_ctl_stb <= 1'b0;
      bus_ctl     <= '0;
      bus_req     <= 1'b0;
      bus_we      <= 1'b0;
      bus_addr    <= '0;
      bus_wdata   <= '0;
      done        <= 1'b0;
    end else begin
      done        <= 1'b0;
      bus_ctl_stb <= 1'b0;
      unique case (state)
        S_IDLE: if (cmd_start) begin
          dir_q      <= cmd_dir;
          size_q     <= size_e'(cmd_size);
          words_left <= cmd_count;
          mem_addr   <= mem_top;
          bus_addr   <= bus_top;
          item_idx   <= '0;
          data_q     <= '0;
          if (cmd_count == '0) begin
            done <= 1'b1;
          end else begin
            state       <= S_CTL;
            bus_ctl_stb <= 1'b1;
            bus_ctl     <= cmd_dir ? CTL_RD : CTL_WR;
          end
        end
        S_CTL: begin
          if (dir_q) begin
            bus_req <= 1'b1;
            bus_we  <= 1'b0;
            state   <= S_BIN;
          end else begin
            mem_req <= 1'b1;
            mem_we  <= 1'b0;
            state   <= S_MRD;
          end
        end
        S_MRD: if (mem_rdy) begin
          mem_req   <= 1'b0;
          mem_addr  <= mem_addr - MEM_AW'(1);
          data_q    <= load_val;
          bus_wdata <= load_item;
          bus_req   <= 1'b1;
          bus_we    <= 1'b1;
          item_idx  <= '0;
          state     <= S_BOUT;
        end
        S_BOUT: if (bus_rdy) begin
          bus_addr <= bus_addr - BUS_AW'(1);
          if (item_idx == last_idx) begin
            bus_req    <= 1'b0;
            words_left <= words_left - CNT_W'(1);
            if (last_word) begin
              done  <= 1'b1;
              state <= S_IDLE;
            end else begin
              mem_req <= 1'b1;
              state   <= S_MRD;
            end
          end else begin
            item_idx  <= item_idx + 2'd1;
            data_q    <= rot_val;
            bus_wdata <= rot_item;
          end
        end
        S_BIN: if (bus_rdy) begin
          bus_addr <= bus_addr - BUS_AW'(1);
          data_q   <= asm_val;
          if (item_idx == last_idx) begin
            bus_req   <= 1'b0;
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_wdata <= asm_val;
            state     <= S_MWR;
          end else begin
            item_idx <= item_idx + 2'd1;
          end
        end
        S_MWR: if (mem_rdy) begin
          mem_req    <= 1'b0;
          mem_addr   <= mem_addr - MEM_AW'(1);
          words_left <= words_left - CNT_W'(1);
          item_idx   <= '0;
          data_q     <= '0;
          if (last_word) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            bus_req <= 1'b1;
            bus_we  <= 1'b0;
            state   <= S_BIN;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pack_xfer_engine_chk.sv
module pack_xfer_engine_chk #(
  parameter int MEM_AW = 10,
  parameter int BUS_AW = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req,
  input logic              mem_we,
  input logic [MEM_AW-1:0] mem_addr,
  input logic [15:0]       mem_wdata,
  input logic              mem_rdy,
  input logic              bus_ctl_stb,
  input logic [1:0]        bus_ctl,
  input logic              bus_req,
  input logic              bus_we,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [15:0]       bus_wdata,
  input logic              bus_rdy,
  input logic              done
);
  a_r3_ctl_alone: assert property (@(posedge clk) disable iff (rst)
    bus_ctl_stb |-> (!bus_req && !mem_req));
  a_r3_ctl_single: assert property (@(posedge clk) disable iff (rst)
    bus_ctl_stb |=> !bus_ctl_stb);
  a_r3_ctl_code: assert property (@(posedge clk) disable iff (rst)
    bus_ctl_stb |-> (bus_ctl == 2'd1 || bus_ctl == 2'd2));
  a_r4_mem_step: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_rdy) |=> (mem_addr == $past(mem_addr) - MEM_AW'(1)));
  a_r5_bus_step: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_rdy) |=> (bus_addr == $past(bus_addr) - BUS_AW'(1)));
  a_r11_bus_hold: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_rdy) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));
  a_r11_mem_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
  a_r12_excl: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && bus_req));
  a_r12_done_quiet: assert property (@(posedge clk) disable iff (rst)
    done |-> (!mem_req && !bus_req && !bus_ctl_stb));
endmodule

bind pack_xfer_engine pack_xfer_engine_chk #(.MEM_AW(MEM_AW), .BUS_AW(BUS_AW)) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_rdy(mem_rdy), .bus_ctl_stb(bus_ctl_stb), .bus_ctl(bus_ctl),
  .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdy(bus_rdy), .done(done)
);

// File: tb/pack_xfer_engine_tb.sv
`timescale 1ns/1ps
module pack_xfer_engine_tb;
  localparam int MAW = 8;
  localparam int BAW = 10;
  localparam int CW  = 6;
  localparam int MN  = 1 << MAW;
  localparam int BN  = 1 << BAW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_start = 1'b0, cmd_dir = 1'b0;
  logic [1:0] cmd_size = '0;
  logic [MAW-1:0] cmd_mem_base = '0;
  logic [BAW-1:0] cmd_bus_base = '0;
  logic [CW-1:0] cmd_count = '0;
  logic mem_req, mem_we, mem_rdy = 1'b0;
  logic [MAW-1:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic bus_ctl_stb, bus_req, bus_we, bus_rdy = 1'b0, done;
  logic [1:0] bus_ctl;
  logic [BAW-1:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata;

  logic [15:0] mem_arr [MN];
  logic [15:0] bus_arr [BN];
  logic [15:0] exp_mem [MN];
  logic [15:0] exp_bus [BN];

  int n_chk = 0, n_fail = 0;
  int mem_acc = 0, bus_acc = 0, ctl_cnt = 0, done_cnt = 0;
  logic [1:0] last_ctl = '0;
  bit arm_m = 0, arm_b = 0;
  int first_m = -1, first_b = -1;
  bit load_en = 1'b1;

  always #2.5 clk = ~clk;

  pack_xfer_engine #(.MEM_AW(MAW), .BUS_AW(BAW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_dir(cmd_dir), .cmd_size(cmd_size),
    .cmd_mem_base(cmd_mem_base), .cmd_bus_base(cmd_bus_base), .cmd_count(cmd_count),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rdy(mem_rdy), .bus_ctl_stb(bus_ctl_stb), .bus_ctl(bus_ctl),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rdy(bus_rdy), .done(done)
  );

  assign mem_rdata = mem_arr[mem_addr];
  assign bus_rdata = bus_arr[bus_addr];

  always @(posedge clk) begin
    if (load_en) begin
      for (int i = 0; i < MN; i++) mem_arr[i] <= 16'($urandom);
      for (int i = 0; i < BN; i++) bus_arr[i] <= 16'($urandom);
    end else if (!rst) begin
      if (bus_ctl_stb) begin ctl_cnt <= ctl_cnt + 1; last_ctl <= bus_ctl; arm_m <= 1; arm_b <= 1; end
      if (done) done_cnt <= done_cnt + 1;
      if (mem_req && mem_rdy) begin
        mem_acc <= mem_acc + 1;
        if (mem_we) mem_arr[mem_addr] <= mem_wdata;
        if (arm_m) begin first_m <= int'(mem_addr); arm_m <= 0; end
      end
      if (bus_req && bus_rdy) begin
        bus_acc <= bus_acc + 1;
        if (bus_we) bus_arr[bus_addr] <= bus_wdata;
        if (arm_b) begin first_b <= int'(bus_addr); arm_b <= 0; end
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    forever begin
      @(negedge clk);
      mem_rdy = ($urandom % 4) != 0;
      bus_rdy = ($urandom % 3) != 0;
    end
  end

  task automatic chk(input string req, input bit ok, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ipw(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd3) ? 4 : 2;
  endfunction

  function automatic logic [15:0] out_item(input logic [1:0] sz, input logic [15:0] w, input int j);
    case (sz)
      2'd0: return w;
      2'd1: return (j == 0) ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
      2'd2: return (j == 0) ? {8'h00, w[7:0]} : {8'h00, w[15:8]};
      default: return {12'h000, w[4*j +: 4]};
    endcase
  endfunction

  task automatic run(input bit d, input logic [1:0] sz, input int mb, input int bb,
                     input int cnt, input bit poke);
    int k, m0, b0, c0, d0, t, bad;
    string tag;
    k = ipw(sz);
    for (int i = 0; i < MN; i++) exp_mem[i] = mem_arr[i];
    for (int i = 0; i < BN; i++) exp_bus[i] = bus_arr[i];
    for (int i = 0; i < cnt; i++) begin
      if (!d) begin
        for (int j = 0; j < k; j++) exp_bus[bb + i*k + (k-1-j)] = out_item(sz, exp_mem[mb+i], j);
      end else begin
        logic [15:0] w;
        logic [15:0] a0, a1;
        a0 = exp_bus[bb + i*k + (k-1)];
        a1 = (k > 1) ? exp_bus[bb + i*k + (k-2)] : 16'h0;
        case (sz)
          2'd0: w = a0;
          2'd1: w = {a0[7:0], a1[7:0]};
          2'd2: w = {a1[7:0], a0[7:0]};
          default: for (int j = 0; j < 4; j++) w[4*j +: 4] = exp_bus[bb + i*k + (3-j)][3:0];
        endcase
        exp_mem[mb+i] = w;
      end
    end
    if (d) tag = "R10 input assembly";
    else case (sz)
      2'd0: tag = "R6 word out";
      2'd1: tag = "R7 byte out";
      2'd2: tag = "R8 swapped out";
      default: tag = "R9 nibble out";
    endcase
    m0 = mem_acc; b0 = bus_acc; c0 = ctl_cnt; d0 = done_cnt;
    @(negedge clk);
    cmd_dir = d; cmd_size = sz; cmd_mem_base = MAW'(mb); cmd_bus_base = BAW'(bb);
    cmd_count = CW'(cnt); cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    if (cnt == 0) begin
      chk("R2 done next cycle", done == 1'b1, done, 1);
      repeat (4) @(negedge clk);
      chk("R2 no activity", (mem_acc == m0) && (bus_acc == b0) && (ctl_cnt == c0),
          (mem_acc - m0) + (bus_acc - b0) + (ctl_cnt - c0), 0);
      chk("R2 single done", done_cnt - d0 == 1, done_cnt - d0, 1);
    end else begin
      if (poke) begin
        repeat (3) @(negedge clk);
        cmd_dir = ~d; cmd_size = sz ^ 2'd1; cmd_count = CW'(5); cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
      end
      t = 0;
      while (done_cnt == d0 && t < 20000) begin @(negedge clk); t++; end
      repeat (4) @(negedge clk);
      chk(poke ? "R1 single done while busy start" : "R12 single done", done_cnt - d0 == 1, done_cnt - d0, 1);
      chk(poke ? "R1 single ctl strobe" : "R3 single ctl strobe", ctl_cnt - c0 == 1, ctl_cnt - c0, 1);
      chk("R3 ctl code", last_ctl == (d ? 2'd1 : 2'd2), last_ctl, d ? 1 : 2);
      chk("R4 first mem addr", first_m == mb + cnt - 1, first_m, mb + cnt - 1);
      chk("R5 first bus addr", first_b == bb + cnt*k - 1, first_b, bb + cnt*k - 1);
      chk("R11 access counts", (mem_acc - m0 == cnt) && (bus_acc - b0 == cnt*k),
          (mem_acc - m0) * 1000 + (bus_acc - b0), cnt * 1000 + cnt*k);
    end
    bad = -1;
    for (int i = 0; i < MN; i++) if (bad < 0 && mem_arr[i] !== exp_mem[i]) bad = i;
    if (bad >= 0) chk({tag, " mem image"}, 0, mem_arr[bad], exp_mem[bad]);
    else chk({tag, " mem image"}, 1, 0, 0);
    bad = -1;
    for (int i = 0; i < BN; i++) if (bad < 0 && bus_arr[i] !== exp_bus[i]) bad = i;
    if (bad >= 0) chk({tag, " bus image"}, 0, bus_arr[bad], exp_bus[bad]);
    else chk({tag, " bus image"}, 1, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    load_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12 reset quiet", !done && !mem_req && !bus_req && !bus_ctl_stb,
        {done, mem_req, bus_req, bus_ctl_stb}, 0);
    rst = 1'b0;
    @(negedge clk);
    run(0, 2'd0, 10, 20, 0, 0);
    run(1, 2'd3, 10, 20, 0, 0);
    for (int s = 0; s < 4; s++) begin
      run(0, 2'(s), 5, 100, 1, 0);
      run(1, 2'(s), 30, 300, 1, 0);
    end
    run(0, 2'd3, 0, 0, 63, 0);
    run(1, 2'd3, 100, 500, 63, 0);
    run(0, 2'd1, 40, 40, 6, 1);
    run(1, 2'd2, 60, 700, 6, 1);
    for (int n = 0; n < 24; n++) begin
      logic [1:0] sz;
      int cnt, k, mb, bb;
      sz = 2'($urandom % 4);
      k = ipw(sz);
      cnt = 1 + int'($urandom % 40);
      mb = int'($urandom % (MN - cnt));
      bb = int'($urandom % (BN - cnt*k));
      run(1'($urandom % 2), sz, mb, bb, cnt, 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R12 actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule